// File: doc/BRIEF.md
# Dual-Channel Bus-Master IDE Register Block

This block holds the software-visible control state of a two-channel bus-master IDE DMA engine. It sits behind a 16-byte I/O window that is reached through a simple synchronous register bus. The bus has a 32-bit word address, four byte enables, and write and read data. Each channel owns one 8-byte half of the window. The lower word of each half carries four byte registers: a command byte, a mode/interrupt byte shared by both channels, a status byte, and a per-channel timing byte. The upper word is the 32-bit descriptor table address.

Two level-sensitive channel interrupt inputs are latched into pending bits of the shared mode byte. Software can mask each channel with a block bit in the same byte. The single interrupt output is high whenever some channel is pending and not blocked. The DMA engine drives an active flag into each status byte. It also pulses error and interrupt events, which software clears by writing ones.

A build parameter can remove the extended registers, meaning the mode byte and the timing bytes. With them removed, those byte lanes read as all ones and writes to them have no effect.

Top module: `ide_bm_regs`

## Requirements
- R1: While reset is asserted, every register returns to zero. After reset, every word reads zero (the extended lanes read 0xFF when they are removed) and the interrupt output is low.
- R2: Byte lane 0 of a channel's control word (offset 0 of the channel) is a command byte. It reads back the last value written to it, and each channel has its own copy.
- R3: Byte lane 1 (offset 1) of either channel reads the same shared mode byte. A write to that lane changes only bit 4 (channel 0 block) and bit 5 (channel 1 block). When both channels write the lane in the same cycle, channel 1's data is kept.
- R4: Mode bit 2 equals channel 0's interrupt input level and mode bit 3 equals channel 1's, both as sampled at the previous clock edge. Bits 0, 1, 6 and 7 read zero.
- R5: `irq_out` is high exactly when (mode bit 2 and not bit 4) or (mode bit 3 and not bit 5). It follows a change of the block bits in the cycle after the write.
- R6: Status byte (lane 2, offset 2): writes load bits 5 and 6. Bit 0 reads the channel's DMA active input from the previous edge and cannot be written. Bits 3, 4 and 7 always read zero.
- R7: Status bit 1 (error) and bit 2 (interrupt) are set by one-cycle event pulses. A write clears such a bit where the written bit is 1 and leaves it unchanged where the written bit is 0. A set pulse in the same cycle as a clearing write leaves the bit set.
- R8: Byte lane 3 (offset 3) is a timing byte with separate storage for each channel, readable and writable.
- R9: The upper word of each channel (offsets 4 to 7) is a 32-bit descriptor address. Each byte is written only when its byte enable is set, so byte, 16-bit and 32-bit writes all work.
- R10: With `EXT_EN` = 0, lanes 1 and 3 of the control words read 0xFF, writes to them are ignored, and the block bits therefore stay zero.
- R11: Read data is registered. It shows the addressed word one cycle after the read strobe, with lanes whose byte enable is clear reading zero, and it holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word index: bit 1 selects channel, bit 0 selects control word (0) or descriptor address (1) |
| bus_be | input | 4 | Byte enables, bit n for lane n (byte offset n within the word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_irq_in | input | 2 | Channel interrupt request levels, bit n for channel n |
| dma_active | input | 2 | DMA engine active flag per channel |
| dma_err_set | input | 2 | Error event pulse per channel |
| dma_int_set | input | 2 | Interrupt event pulse per channel |
| irq_out | output | 1 | Combined level-sensitive interrupt |

## Verification
Most state in this block becomes visible on the next read of the word that holds it. A wrongly latched status or block bit therefore shows up in `bus_rdata` exactly one cycle after the read strobe. A wrong pending or block bit also shows on `irq_out` in the cycle after the input change or write that should have moved it. The tests therefore read back every word after each change. They sample `irq_out` one edge after each interrupt input change and each block write. This covers the cases where a clear and a set meet in the same cycle, and where one lane write must leave the neighbouring bits alone.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

    localparam int CH_N    = 2;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int ADDR_W  = $clog2(CH_N * 2);

    // byte lanes of a channel control word
    localparam int LANE_CMD  = 0;
    localparam int LANE_MODE = 1;
    localparam int LANE_STAT = 2;
    localparam int LANE_TIM  = 3;

    // bit positions inside the status and mode bytes
    localparam int ST_ACT   = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_INT   = 2;
    localparam int ST_CAP   = 5;
    localparam int MD_PEND  = 2;
    localparam int MD_BLK   = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] tim;
        logic [1:0]        cap;
        logic              intr;
        logic              err;
        logic              act;
        logic [WORD_W-1:0] dtab;
    } chan_regs_t;

    function automatic logic [BYTE_W-1:0] stat_pack(chan_regs_t r);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[ST_ACT]          = r.act;
        s[ST_ERR]          = r.err;
        s[ST_INT]          = r.intr;
        s[ST_CAP +: 2]     = r.cap;
        return s;
    endfunction

    // write-one-to-clear with set priority
    function automatic logic w1c_next(logic cur, logic set, logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
    import ide_bm_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_tab,
    input  logic [LANES-1:0]  be,
    input  logic [WORD_W-1:0] wdata,
    input  logic              act_in,
    input  logic              err_set,
    input  logic              int_set,
    output chan_regs_t        regs
);

    localparam int STAT_LSB = LANE_STAT * BYTE_W;

    logic stat_we;
    assign stat_we = wr_ctl && be[LANE_STAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            regs.act  <= act_in;
            regs.err  <= w1c_next(regs.err, err_set,
                                  stat_we && wdata[STAT_LSB + ST_ERR]);
            regs.intr <= w1c_next(regs.intr, int_set,
                                  stat_we && wdata[STAT_LSB + ST_INT]);
            if (stat_we)
                regs.cap <= wdata[STAT_LSB + ST_CAP +: 2];
            if (wr_ctl && be[LANE_CMD])
                regs.cmd <= wdata[LANE_CMD*BYTE_W +: BYTE_W];
            if (EXT_EN && wr_ctl && be[LANE_TIM])
                regs.tim <= wdata[LANE_TIM*BYTE_W +: BYTE_W];
            for (int l = 0; l < LANES; l++) begin
                if (wr_tab && be[l])
                    regs.dtab[l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/ide_bm_irq.sv
module ide_bm_irq
    import ide_bm_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CH_N-1:0]            irq_in,
    input  logic [CH_N-1:0]            blk_we,
    input  logic [CH_N-1:0][CH_N-1:0]  blk_wd,
    output logic [BYTE_W-1:0]          mode_byte,
    output logic                       irq_out
);

    logic [CH_N-1:0] pend_q;
    logic [CH_N-1:0] blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            blk_q  <= '0;
        end else begin
            pend_q <= irq_in;
            // higher channel index is applied last and wins
            for (int c = 0; c < CH_N; c++) begin
                if (blk_we[c])
                    blk_q <= blk_wd[c];
            end
        end
    end

    always_comb begin
        mode_byte = '0;
        mode_byte[MD_PEND +: CH_N] = pend_q;
        mode_byte[MD_BLK  +: CH_N] = blk_q;
    end

    assign irq_out = |(pend_q & ~blk_q);

endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
    import ide_bm_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [CH_N-1:0]   ch_irq_in,
    input  logic [CH_N-1:0]   dma_active,
    input  logic [CH_N-1:0]   dma_err_set,
    input  logic [CH_N-1:0]   dma_int_set,
    output logic              irq_out
);

    localparam logic [BYTE_W-1:0] ABSENT = '1;

    chan_regs_t                      chan_q [CH_N];
    logic [CH_N-1:0][BYTE_W-1:0]     stat_q;
    logic [CH_N-1:0][WORD_W-1:0]     ctl_word;
    logic [CH_N-1:0]                 blk_we;
    logic [CH_N-1:0][CH_N-1:0]       blk_wd;
    logic [BYTE_W-1:0]               mode_byte;

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        logic wr_ctl, wr_tab;
        assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(2*ch));
        assign wr_tab = bus_wr && (bus_addr == ADDR_W'(2*ch + 1));

        ide_bm_chan #(.EXT_EN(EXT_EN)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_ctl  (wr_ctl),
            .wr_tab  (wr_tab),
            .be      (bus_be),
            .wdata   (bus_wdata),
            .act_in  (dma_active[ch]),
            .err_set (dma_err_set[ch]),
            .int_set (dma_int_set[ch]),
            .regs    (chan_q[ch])
        );

        assign blk_we[ch] = EXT_EN && wr_ctl && bus_be[LANE_MODE];
        assign blk_wd[ch] = bus_wdata[LANE_MODE*BYTE_W + MD_BLK +: CH_N];
        assign stat_q[ch] = stat_pack(chan_q[ch]);

        if (EXT_EN) begin : g_ext
            assign ctl_word[ch] = {chan_q[ch].tim, stat_q[ch], mode_byte, chan_q[ch].cmd};
        end else begin : g_noext
            assign ctl_word[ch] = {ABSENT, stat_q[ch], ABSENT, chan_q[ch].cmd};
        end
    end

    ide_bm_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (ch_irq_in),
        .blk_we    (blk_we),
        .blk_wd    (blk_wd),
        .mode_byte (mode_byte),
        .irq_out   (irq_out)
    );

    logic [WORD_W-1:0] rd_word;
    always_comb begin
        rd_word = bus_addr[0] ? chan_q[bus_addr[1]].dtab : ctl_word[bus_addr[1]];
        for (int l = 0; l < LANES; l++) begin
            if (!bus_be[l])
                rd_word[l*BYTE_W +: BYTE_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_word;
    end

endmodule

// File: rtl/ide_bm_regs_chk.sv
module ide_bm_regs_chk
    import ide_bm_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_rd,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [LANES-1:0]          bus_be,
    input logic [WORD_W-1:0]         bus_rdata,
    input logic [CH_N-1:0]           ch_irq_in,
    input logic [CH_N-1:0]           dma_err_set,
    input logic [CH_N-1:0]           dma_int_set,
    input logic [CH_N-1:0][BYTE_W-1:0] stat_q,
    input logic                      irq_out
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0) && !irq_out);

    // R5
    no_request_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_irq_in == '0) |=> !irq_out);

    // R7
    int_event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        dma_int_set[0] |=> stat_q[0][ST_INT]);

    // R7
    err_event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        dma_err_set[1] |=> stat_q[1][ST_ERR]);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R10
    absent_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (!EXT_EN && bus_rd && !bus_addr[0] && bus_be[LANE_MODE])
            |=> (bus_rdata[LANE_MODE*BYTE_W +: BYTE_W] == 8'hFF));

endmodule

bind ide_bm_regs ide_bm_regs_chk #(.EXT_EN(EXT_EN)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_rdata   (bus_rdata),
    .ch_irq_in   (ch_irq_in),
    .dma_err_set (dma_err_set),
    .dma_int_set (dma_int_set),
    .stat_q      (stat_q),
    .irq_out     (irq_out)
);

// File: tb/ide_bm_regs_tb.sv
module ide_bm_regs_tb_top;

    localparam int CLK_P   = 10;
    localparam int N_VEC   = 11;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] rdata, rdata_n;
    logic [1:0]  ch_irq_in, dma_active, dma_err_set, dma_int_set;
    logic        irq, irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ide_bm_regs #(.EXT_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .ch_irq_in(ch_irq_in), .dma_active(dma_active),
        .dma_err_set(dma_err_set), .dma_int_set(dma_int_set), .irq_out(irq)
    );

    ide_bm_regs #(.EXT_EN(1'b0)) dut_noext_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_n), .ch_irq_in(ch_irq_in), .dma_active(dma_active),
        .dma_err_set(dma_err_set), .dma_int_set(dma_int_set), .irq_out(irq_n)
    );

    // {word addr, byte enables, write data, expected read of same word}
    localparam logic [69:0] VEC [N_VEC] = '{
        {2'd0, 4'b0001, 32'h000000A5, 32'h000000A5},  // R2 cmd ch0
        {2'd2, 4'b1001, 32'h7E00003C, 32'h7E00003C},  // R2 R8 ch1
        {2'd0, 4'b1000, 32'h11000000, 32'h110000A5},  // R8 timing ch0
        {2'd0, 4'b0100, 32'h00FF0000, 32'h116000A5},  // R6 status mask
        {2'd0, 4'b0010, 32'h0000FF00, 32'h116030A5},  // R3 only block bits
        {2'd2, 4'b0010, 32'h00001000, 32'h7E00103C},  // R3 shared from ch1
        {2'd1, 4'b1111, 32'hDEADBEEF, 32'hDEADBEEF},  // R9 word write
        {2'd1, 4'b0101, 32'h12345678, 32'hDE34BE78},  // R9 byte enables
        {2'd3, 4'b0011, 32'h0000CAFE, 32'h0000CAFE},  // R9 half word
        {2'd3, 4'b1100, 32'hFACE0000, 32'hFACECAFE},  // R9 upper half
        {2'd0, 4'b0000, 32'hFFFFFFFF, 32'h116010A5}   // R9 no enables
    };

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_wr(logic [1:0] a, logic [3:0] be, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_be = 4'b0;
    endtask

    task automatic do_rd(logic [1:0] a);
        bus_rd = 1'b1; bus_addr = a; bus_be = 4'b1111;
        cyc();
        bus_rd = 1'b0; bus_be = 4'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
        bus_be = '0; bus_wdata = '0; ch_irq_in = '0; dma_active = '0;
        dma_err_set = '0; dma_int_set = '0;
        repeat (3) cyc();
        rst = 1'b0;

        // R1 reset state
        for (int w = 0; w < 4; w++) begin
            do_rd(2'(w));
            check("R1 reset word", rdata, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        do_rd(2'd0);
        check("R10 absent lanes after reset", rdata_n, 32'hFF00FF00);

        // table walk
        for (int i = 0; i < N_VEC; i++) begin
            do_wr(VEC[i][69:68], VEC[i][67:64], VEC[i][63:32]);
            do_rd(VEC[i][69:68]);
            check($sformatf("R2/R3/R6/R8/R9 vector %0d", i), rdata, VEC[i][31:0]);
        end

        // R4 R5 interrupt pending and masking (block = ch0 only)
        ch_irq_in = 2'b01; cyc();
        check("R5 blocked ch0", {31'b0, irq}, 32'h0);
        check("R10 no block bits", {31'b0, irq_n}, 32'h1);
        do_rd(2'd0);
        check("R4 pend ch0", rdata, 32'h116014A5);
        ch_irq_in = 2'b11; cyc();
        check("R5 ch1 unblocked", {31'b0, irq}, 32'h1);
        do_rd(2'd2);
        check("R4 pend both via ch1", rdata, 32'h7E001C3C);
        do_wr(2'd0, 4'b0010, 32'h00003000);
        check("R5 both blocked", {31'b0, irq}, 32'h0);
        do_rd(2'd0);
        check("R3 pend kept on block write", rdata, 32'h11603CA5);
        do_wr(2'd2, 4'b0010, 32'h00000000);
        check("R5 unblocked all", {31'b0, irq}, 32'h1);
        ch_irq_in = 2'b00; cyc();
        check("R4 pend follows low", {31'b0, irq}, 32'h0);

        // R3 simultaneous block write from both channel lanes is not
        // reachable through one word address; ch1 path already covered.

        // R7 events and write-one-to-clear
        dma_int_set = 2'b01; dma_err_set = 2'b01; cyc();
        dma_int_set = 2'b00; dma_err_set = 2'b00;
        do_rd(2'd0);
        check("R7 events set ch0", rdata, 32'h116600A5);
        dma_err_set = 2'b10; cyc(); dma_err_set = 2'b00;
        do_rd(2'd2);
        check("R7 error ch1", rdata, 32'h7E02003C);
        do_wr(2'd2, 4'b0100, 32'h00200000);
        do_rd(2'd2);
        check("R7 zero write keeps flag", rdata, 32'h7E22003C);
        do_wr(2'd0, 4'b0100, 32'h00FF0000);
        do_rd(2'd0);
        check("R6 R7 clear and load", rdata, 32'h116000A5);
        dma_err_set = 2'b01;
        do_wr(2'd0, 4'b0100, 32'h00020000);
        dma_err_set = 2'b00;
        do_rd(2'd0);
        check("R7 set wins over clear", rdata, 32'h110200A5);

        // R6 active flag is read-only
        dma_active = 2'b01; cyc();
        do_wr(2'd0, 4'b0100, 32'h00010000);
        do_rd(2'd0);
        check("R6 active shown", rdata, 32'h110300A5);
        dma_active = 2'b00; cyc();
        do_rd(2'd0);
        check("R6 active drops", rdata, 32'h110200A5);

        // R11 hold without read, then R2 update visible
        do_wr(2'd0, 4'b0001, 32'h000000FF);
        check("R11 hold", rdata, 32'h110200A5);
        do_rd(2'd0);
        check("R2 cmd rewrite", rdata, 32'h110200FF);
        check("R10 absent lanes", rdata_n, 32'hFF02FFFF);

        // R11 disabled lanes read zero
        bus_rd = 1'b1; bus_addr = 2'd1; bus_be = 4'b0110;
        cyc();
        bus_rd = 1'b0; bus_be = 4'b0;
        check("R11 masked lanes", rdata, 32'h0034BE00);

        // R1 second reset
        rst = 1'b1; cyc(); cyc(); rst = 1'b0;
        for (int w = 0; w < 4; w++) begin
            do_rd(2'(w));
            check("R1 reset again", rdata, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule